// File: doc/BRIEF.md
# Wake-up Window Threshold Comparator

This block watches the three signed field measurements (X, Y and Z) produced by a conversion engine. It compares each new set of results against a lower and an upper threshold per axis, and on an out-of-window result it sends an active-low interrupt pulse to the host. Each threshold is a signed 11-bit value. Its upper eight bits come from a per-threshold byte, and its lowest three bits come from a 6-bit field word shared by the two thresholds of that axis.

The window check runs only while wake-up operation is active. Wake-up operation is active when software has enabled it, no test mode is running, the configuration parity check passes and the configuration-valid flag is set. While wake-up is inactive, the block falls back to plain data-ready signalling: every completed conversion produces a pulse. A separate disable input suppresses the interrupt output in both cases. The active state is reported on a status output.

Top module: `wake_window_cmp`

## Requirements
- R1: Each threshold is the signed 11-bit value {MSB byte, 3-bit LSB field}. In the per-axis 6-bit LSB word, bits [5:3] hold the upper-threshold LSBs and bits [2:0] hold the lower-threshold LSBs.
- R2: Each axis compares bits [11:1] of its 12-bit signed measurement against its thresholds. An axis fires when that value is greater than or equal to the upper threshold, or less than or equal to the lower threshold. Both bounds are inclusive.
- R3: `wake_active` goes to 1 one clock after `wu_en`=1, `test_on`=0, `cfg_par_ok`=1 and `cfg_flag`=1 all hold together. It returns to 0 one clock after any of these four conditions fails.
- R4: While `wake_active`=1 and `int_dis`=0, a `conv_done` strobe starts a pulse if at least one axis fires, and starts nothing if no axis fires.
- R5: While `wake_active`=0 and `int_dis`=0, every `conv_done` strobe starts a pulse, whatever the measurement values are.
- R6: A pulse drives `int_n` low for exactly PULSE_CYC clocks (default 4), starting in the cycle after the strobe edge. Each strobe gives a single pulse, however many axes fire.
- R7: A strobe that arrives while a pulse is already in progress is ignored. The pulse is neither extended nor restarted.
- R8: While `int_dis`=1, `int_n` is 1 in the same cycle, any pulse in progress ends, and strobes start no pulse.
- R9: After reset, `int_n`=1 and `wake_active`=0.
- R10: With the threshold inputs at their power-on encodings (MSB 80h for the lower threshold, 7Fh for the upper threshold, LSB word 38h), only measurements whose upper 11 bits equal -1024 or +1023 fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new set of measurements is valid |
| meas_x | input | 12 | X measurement, signed |
| meas_y | input | 12 | Y measurement, signed |
| meas_z | input | 12 | Z measurement, signed |
| lo_msb_x | input | 8 | X lower threshold, upper bits |
| hi_msb_x | input | 8 | X upper threshold, upper bits |
| lsb_x | input | 6 | X threshold LSB word: [5:3] upper, [2:0] lower |
| lo_msb_y | input | 8 | Y lower threshold, upper bits |
| hi_msb_y | input | 8 | Y upper threshold, upper bits |
| lsb_y | input | 6 | Y threshold LSB word |
| lo_msb_z | input | 8 | Z lower threshold, upper bits |
| hi_msb_z | input | 8 | Z upper threshold, upper bits |
| lsb_z | input | 6 | Z threshold LSB word |
| wu_en | input | 1 | Software wake-up enable |
| test_on | input | 1 | A test mode is running |
| cfg_par_ok | input | 1 | Configuration odd parity is correct |
| cfg_flag | input | 1 | Configuration-valid flag |
| int_dis | input | 1 | 1 suppresses the interrupt output |
| int_n | output | 1 | Active-low interrupt pulse |
| wake_active | output | 1 | Wake-up operation is active |

## Verification
The assertions assume that `conv_done` is a strobe sampled on clock edges and that `int_dis` and the four enable inputs change only between edges. The bench meets this by driving every input on the falling edge. The assertions also assume that the threshold and measurement inputs are stable in the cycle of a strobe. The bench therefore sets the thresholds and measurements on the falling edge where the strobe rises, and changes the thresholds only while no strobe is pending. The disable input is raised only between strobes, or in the middle of a pulse, so that the cut-off check sees a pulse that had really started.

// File: rtl/wkw_pkg.sv
package wkw_pkg;
  // Axis indices used by the per-axis generate loop
  typedef enum logic [1:0] {AX_X = 2'd0, AX_Y = 2'd1, AX_Z = 2'd2} axis_e;
  localparam int unsigned AXIS_N = 3;
endpackage

// File: rtl/wkw_thr_form.sv
// Builds the signed lower and upper thresholds of one axis from the MSB bytes
// and the shared LSB word.
module wkw_thr_form #(
  parameter int unsigned MSB_W = 8,
  parameter int unsigned LSB_W = 3,
  localparam int unsigned THR_W = MSB_W + LSB_W
) (
  input  logic [MSB_W-1:0]   msb_lo,
  input  logic [MSB_W-1:0]   msb_hi,
  input  logic [2*LSB_W-1:0] lsb_word,
  output logic [THR_W-1:0]   thr_lo,
  output logic [THR_W-1:0]   thr_hi
);
  function automatic logic [THR_W-1:0] join_thr(logic [MSB_W-1:0] m, logic [LSB_W-1:0] l);
    return {m, l};
  endfunction

  // R1: upper-threshold LSBs sit in the upper half of the word
  assign thr_hi = join_thr(msb_hi, lsb_word[2*LSB_W-1:LSB_W]);
  assign thr_lo = join_thr(msb_lo, lsb_word[LSB_W-1:0]);
endmodule

// File: rtl/wkw_axis_cmp.sv
// Inclusive window check of one axis. Comparing the full-width measurement
// against the threshold padded with ones (lower) or zeros (upper) is the same
// as comparing the truncated measurement, and every input bit takes part.
module wkw_axis_cmp #(
  parameter int unsigned MEAS_W = 12,
  parameter int unsigned THR_W  = 11,
  localparam int unsigned DROP  = MEAS_W - THR_W
) (
  input  logic [MEAS_W-1:0] meas,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [THR_W-1:0]  thr_hi,
  output logic              fire_lo,
  output logic              fire_hi
);
  function automatic logic at_or_above(logic [MEAS_W-1:0] m, logic [THR_W-1:0] t);
    return $signed(m) >= $signed({t, {DROP{1'b0}}});
  endfunction

  function automatic logic at_or_below(logic [MEAS_W-1:0] m, logic [THR_W-1:0] t);
    return $signed(m) <= $signed({t, {DROP{1'b1}}});
  endfunction

  // R2
  assign fire_hi = at_or_above(meas, thr_hi);
  assign fire_lo = at_or_below(meas, thr_lo);
endmodule

// File: rtl/wkw_activate.sv
// Wake-up qualification: registered AND of the four enable conditions.
module wkw_activate (
  input  logic clk,
  input  logic rst_n,
  input  logic wu_en,
  input  logic test_on,
  input  logic cfg_par_ok,
  input  logic cfg_flag,
  output logic wake_active
);
  logic conds_met;
  assign conds_met = wu_en & ~test_on & cfg_par_ok & cfg_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_active <= 1'b0;
    else        wake_active <= conds_met;
  end

  // R3
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_active) |-> $past(wu_en && !test_on && cfg_par_ok && cfg_flag));

  // R3
  wake_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_active) |-> $past(!wu_en || test_on || !cfg_par_ok || !cfg_flag));
endmodule

// File: rtl/wkw_pulse.sv
// Interrupt pulse timer. The pulse starts on a qualified strobe and lasts
// PULSE_CYC clocks. It is not retriggered while running, and the disable
// input cuts it off.
module wkw_pulse #(
  parameter int unsigned PULSE_CYC = 4,
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic fire_any,
  input  logic wake_active,
  input  logic int_dis,
  output logic pulse_start,
  output logic pulse_active,
  output logic int_n
);
  logic [CNT_W-1:0] cnt;
  logic             want;

  // R4, R5: qualify the strobe by window result or data-ready fallback
  assign want         = wake_active ? fire_any : 1'b1;
  assign pulse_active = (cnt != '0);
  // R7, R8: no start while busy or disabled
  assign pulse_start  = conv_done & want & ~int_dis & ~pulse_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (int_dis)      cnt <= '0;
    else if (pulse_start)  cnt <= CNT_W'(PULSE_CYC);
    else if (pulse_active) cnt <= cnt - CNT_W'(1);
  end

  assign int_n = ~pulse_active | int_dis;

  // R4
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(conv_done && !int_dis && (!wake_active || fire_any)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && conv_done && !int_dis) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R8
  disable_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_dis |=> !pulse_active);

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> (cnt == CNT_W'(PULSE_CYC)));
endmodule

// File: rtl/wake_window_cmp.sv
module wake_window_cmp
  import wkw_pkg::*;
#(
  parameter int unsigned MEAS_W    = 12,
  parameter int unsigned MSB_W     = 8,
  parameter int unsigned LSB_W     = 3,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic [MEAS_W-1:0]    meas_x,
  input  logic [MEAS_W-1:0]    meas_y,
  input  logic [MEAS_W-1:0]    meas_z,
  input  logic [MSB_W-1:0]     lo_msb_x,
  input  logic [MSB_W-1:0]     hi_msb_x,
  input  logic [2*LSB_W-1:0]   lsb_x,
  input  logic [MSB_W-1:0]     lo_msb_y,
  input  logic [MSB_W-1:0]     hi_msb_y,
  input  logic [2*LSB_W-1:0]   lsb_y,
  input  logic [MSB_W-1:0]     lo_msb_z,
  input  logic [MSB_W-1:0]     hi_msb_z,
  input  logic [2*LSB_W-1:0]   lsb_z,
  input  logic                 wu_en,
  input  logic                 test_on,
  input  logic                 cfg_par_ok,
  input  logic                 cfg_flag,
  input  logic                 int_dis,
  output logic                 int_n,
  output logic                 wake_active
);
  localparam int unsigned THR_W = MSB_W + LSB_W;

  logic [MEAS_W-1:0]  meas_a   [AXIS_N];
  logic [MSB_W-1:0]   lo_msb_a [AXIS_N];
  logic [MSB_W-1:0]   hi_msb_a [AXIS_N];
  logic [2*LSB_W-1:0] lsb_a    [AXIS_N];
  logic [THR_W-1:0]   thr_lo_a [AXIS_N];
  logic [THR_W-1:0]   thr_hi_a [AXIS_N];
  logic [AXIS_N-1:0]  fire_lo_v, fire_hi_v, axis_fire;
  logic               fire_any, pulse_start, pulse_active;

  assign meas_a[AX_X]   = meas_x;   assign meas_a[AX_Y]   = meas_y;   assign meas_a[AX_Z]   = meas_z;
  assign lo_msb_a[AX_X] = lo_msb_x; assign lo_msb_a[AX_Y] = lo_msb_y; assign lo_msb_a[AX_Z] = lo_msb_z;
  assign hi_msb_a[AX_X] = hi_msb_x; assign hi_msb_a[AX_Y] = hi_msb_y; assign hi_msb_a[AX_Z] = hi_msb_z;
  assign lsb_a[AX_X]    = lsb_x;    assign lsb_a[AX_Y]    = lsb_y;    assign lsb_a[AX_Z]    = lsb_z;

  for (genvar a = 0; a < AXIS_N; a++) begin : g_axis
    wkw_thr_form #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_thr (
      .msb_lo(lo_msb_a[a]), .msb_hi(hi_msb_a[a]), .lsb_word(lsb_a[a]),
      .thr_lo(thr_lo_a[a]), .thr_hi(thr_hi_a[a]));
    wkw_axis_cmp #(.MEAS_W(MEAS_W), .THR_W(THR_W)) u_cmp (
      .meas(meas_a[a]), .thr_lo(thr_lo_a[a]), .thr_hi(thr_hi_a[a]),
      .fire_lo(fire_lo_v[a]), .fire_hi(fire_hi_v[a]));
    assign axis_fire[a] = fire_lo_v[a] | fire_hi_v[a];
  end

  // R6: the axis results merge into one event per strobe
  assign fire_any = |axis_fire;

  wkw_activate u_act (
    .clk(clk), .rst_n(rst_n), .wu_en(wu_en), .test_on(test_on),
    .cfg_par_ok(cfg_par_ok), .cfg_flag(cfg_flag), .wake_active(wake_active));

  wkw_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .fire_any(fire_any),
    .wake_active(wake_active), .int_dis(int_dis), .pulse_start(pulse_start),
    .pulse_active(pulse_active), .int_n(int_n));

  // R4
  in_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_active && conv_done && !fire_any) |-> !pulse_start);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (int_n && !wake_active));
endmodule

// File: tb/tb_wake_window_cmp.sv
module tb_wake_window_cmp;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0, conv_done = 1'b0;
  logic [11:0] meas_x = '0, meas_y = '0, meas_z = '0;
  logic [7:0] lo_msb_x = 8'h80, hi_msb_x = 8'h7F, lo_msb_y = 8'h80, hi_msb_y = 8'h7F;
  logic [7:0] lo_msb_z = 8'h80, hi_msb_z = 8'h7F;
  logic [5:0] lsb_x = 6'h38, lsb_y = 6'h38, lsb_z = 6'h38;
  logic wu_en = 1'b0, test_on = 1'b0, cfg_par_ok = 1'b0, cfg_flag = 1'b0, int_dis = 1'b0;
  logic int_n, wake_active;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_window_cmp dut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of the window: truncated measurement against inclusive signed bounds
  function automatic bit exp_fire(logic [11:0] m, logic [7:0] lm, logic [7:0] hm, logic [5:0] l);
    int mv, lo, hi;
    mv = $signed(m);
    mv = mv >>> 1;
    lo = $signed(lm) * 8 + int'(l[2:0]);
    hi = $signed(hm) * 8 + int'(l[5:3]);
    return (mv >= hi) || (mv <= lo);
  endfunction

  // Strobe once and count the low cycles of int_n that follow
  task automatic strobe(string req, logic [11:0] x, logic [11:0] y, logic [11:0] z, bit exp_pulse);
    int lows;
    @(negedge clk);
    meas_x = x; meas_y = y; meas_z = z; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check({req, " first cycle"}, int_n, exp_pulse ? 0 : 1);
    lows = 0;
    for (int i = 0; i < P + 3; i++) begin
      if (!int_n) lows++;
      @(negedge clk);
    end
    check({req, " low cycles"}, lows, exp_pulse ? P : 0);
  endtask

  task automatic set_enables(bit w, bit t, bit p, bit c);
    @(negedge clk);
    wu_en = w; test_on = t; cfg_par_ok = p; cfg_flag = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9 int_n after reset", int_n, 1);
    check("R9 wake_active after reset", wake_active, 0);
  endtask

  task automatic t_activation;
    set_enables(1, 0, 1, 1); check("R3 all conditions met", wake_active, 1);
    set_enables(1, 1, 1, 1); check("R3 test mode on", wake_active, 0);
    set_enables(1, 0, 0, 1); check("R3 parity bad", wake_active, 0);
    set_enables(1, 0, 1, 0); check("R3 flag clear", wake_active, 0);
    set_enables(0, 0, 1, 1); check("R3 wake-up not enabled", wake_active, 0);
    set_enables(1, 0, 1, 1); check("R3 active again", wake_active, 1);
  endtask

  task automatic t_default_window;
    strobe("R10 -1024 fires", 12'h800, 12'h000, 12'h000, 1);
    strobe("R10 zero quiet", 12'h000, 12'h000, 12'h000, 0);
    strobe("R10 +1023 fires", 12'h000, 12'h7FE, 12'h000, 1);
    strobe("R10 +1022 quiet", 12'h000, 12'h000, 12'h7FD, 0);
    strobe("R10 -1023 quiet", 12'h802, 12'h000, 12'h000, 0);
  endtask

  task automatic t_window;
    @(negedge clk);
    lo_msb_x = 8'hF0; hi_msb_x = 8'h10; lsb_x = {3'd2, 3'd5}; // lower -123, upper 130
    check("R1 model lower bound", exp_fire(12'hF0A, lo_msb_x, hi_msb_x, lsb_x), 1);
    strobe("R2 at upper bound", 12'd260, 12'h000, 12'h000, exp_fire(12'd260, lo_msb_x, hi_msb_x, lsb_x));
    strobe("R1 just below upper", 12'd259, 12'h000, 12'h000, 0);
    strobe("R2 at lower bound", 12'hF0A, 12'h000, 12'h000, 1);  // -246 -> -123
    strobe("R2 odd code truncates to lower", 12'hF0B, 12'h000, 12'h000, 1); // -245 -> -123
    strobe("R4 just above lower quiet", 12'hF0C, 12'h000, 12'h000, 0); // -244 -> -122
    strobe("R6 three axes one pulse", 12'd300, 12'h800, 12'h7FF, 1);
  endtask

  task automatic t_inactive;
    set_enables(1, 1, 1, 1);
    strobe("R5 test mode data-ready pulse", 12'h000, 12'h000, 12'h000, 1);
    set_enables(1, 0, 1, 1);
  endtask

  task automatic t_busy;
    int lows;
    @(negedge clk);
    meas_x = 12'd300; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    @(negedge clk);
    conv_done = 1'b1;           // second strobe inside the pulse
    @(negedge clk);
    conv_done = 1'b0;
    lows = 2;                   // two low samples already passed
    for (int i = 0; i < P + 3; i++) begin
      if (!int_n) lows++;
      @(negedge clk);
    end
    check("R7 strobe during pulse ignored", lows, P);
    meas_x = 12'h000;
  endtask

  task automatic t_disable;
    @(negedge clk);
    meas_x = 12'd300; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check("R8 pulse running", int_n, 0);
    int_dis = 1'b1;
    #1 check("R8 same-cycle suppression", int_n, 1);
    @(negedge clk);
    int_dis = 1'b0;
    #1 check("R8 pulse cut off", int_n, 1);
    int_dis = 1'b1;
    strobe("R8 strobe while disabled", 12'd300, 12'h000, 12'h000, 0);
    int_dis = 1'b0;
    strobe("R8 enabled again", 12'd300, 12'h000, 12'h000, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_activation;
    t_default_window;
    t_window;
    t_inactive;
    t_busy;
    t_disable;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule